// File: doc/BRIEF.md
# Bit-Pattern Lookup Predistorter

This block predistorts one quadrature of a transmitted optical field. Every clock it takes a parallel word of data bits. For each bit it builds a table address from an eleven-bit window of neighbouring transmitted bits, centred on that bit. It then returns two precomputed 6-bit samples for that pattern, one for each half of the bit period. The samples go on to a 6-bit converter through external serialisation. The real and imaginary quadratures each use their own instance. The latency is fixed and does not depend on the data, so two instances fed the same bit stream stay aligned sample for sample.

The window reaches five bits back and five bits ahead of each bit. Any of those bits that fall outside the current word come from a register that holds earlier bits. Each lane has its own copy of the table, so all lanes read in the same cycle. One shared write port updates every copy at once. The tables can be rewritten while data is flowing. The window length is a fixed parameter, because the table size doubles with every bit added to it.

Top module: `pattern_lut_predist`

## Requirements
- R1: While reset is high and on the first cycle after it, `outValid` is 0 and `dataOut` is all zeros.
- R2: A word presented with `inValid` high in cycle c produces exactly one result with `outValid` high in cycle c+2. `outValid` is low in every other cycle.
- R3: Input bit j of the k-th accepted word (counted from 0 after reset) is stream bit k*LANES+j. Output lane j of word k serves stream bit n=k*LANES+j-5. Its pattern address has bit m (m=0..10) equal to stream bit n-5+m, so the oldest bit is the address LSB. Stream bits before the first word count as zero.
- R4: The window keeps its history across word boundaries. Cycles with `inValid` low do not advance the stream or change the window.
- R5: Table entries are addressed by the 12-bit index {pattern, phase}, with the phase in bit 0 of `wrAddr`. The sample for lane j and phase p sits in `dataOut[(2*j+p)*6 +: 6]`.
- R6: A single write updates the same entry in every lane copy. Lanes whose windows carry the same pattern output the same samples.
- R7: A word presented in cycle c reads the table contents that include every write presented in cycle c or earlier. A write presented in cycle c+1 does not affect it: the old data is returned.
- R8: While `outValid` is low, `dataOut` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Data word present this cycle |
| dataIn | input | LANES | Data bits, bit 0 transmitted first |
| wrEn | input | 1 | Table write strobe |
| wrAddr | input | 12 | Write index {pattern, phase} |
| wrData | input | 6 | Sample value to write |
| outValid | output | 1 | Output samples valid |
| dataOut | output | LANES*12 | Two samples per lane, phase 0 in the lower field |

## Verification
The table is filled with values that differ from entry to entry. Constant streams of zeros and ones hit the two extreme patterns, and the all-ones stream shows whether every lane copy agrees. A single isolated one swept through the window exposes any error in address bit order or window centring. Long pseudo-random runs, back to back and with idle gaps, separate correct history carry-over from any slip at word boundaries or during idle cycles. Writes placed in the same cycle as a word and in the cycle after it distinguish new data from old data in the read-during-write case.

// File: rtl/pattern_lut_pkg.sv
package pattern_lut_pkg;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic shiftEn;  // accept a new word into the window register
    logic readEn;   // register table reads for the stored window
    logic writeEn;  // update all lane tables
  } pdStrobe_t;

endpackage

// File: rtl/pd_lane_table.sv
module pd_lane_table #(
  parameter int PAT_W    = 11,
  parameter int SAMPLE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     readEn,
  input  logic [PAT_W-1:0]         rdPat,
  input  logic                     writeEn,
  input  logic [PAT_W-1:0]         wrPat,
  input  logic                     wrPh,
  input  logic [SAMPLE_W-1:0]      wrData,
  output logic [1:0][SAMPLE_W-1:0] rdPair
);

  localparam int DEPTH = 1 << PAT_W;

  // each entry holds both phase samples of one pattern
  logic [1:0][SAMPLE_W-1:0] mem [DEPTH];
  logic [1:0][SAMPLE_W-1:0] rdReg;

  always_ff @(posedge clk) begin
    if (writeEn) mem[wrPat][wrPh] <= wrData;
  end

  // read samples the array before this edge's write: old data on collision
  always_ff @(posedge clk) begin
    if (rst) rdReg <= '0;
    else if (readEn) rdReg <= mem[rdPat];
  end

  assign rdPair = rdReg;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    writeEn |=> mem[$past(wrPat)][$past(wrPh)] == $past(wrData)); // R6

  AST_READ_OLD: assert property (@(posedge clk) disable iff (rst)
    readEn |=> rdReg == $past(mem[rdPat])); // R7

endmodule

// File: rtl/pd_control.sv
module pd_control
  import pattern_lut_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      wrEn,
  output pdStrobe_t strobe,
  output logic      outValid
);

  logic readPend;
  logic validReg;
  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      readPend <= 1'b0;
      validReg <= 1'b0;
    end else begin
      readPend <= inValid;
      validReg <= readPend;
    end
  end

  always_comb begin
    strobe.shiftEn = inValid;
    strobe.readEn  = readPend;
    strobe.writeEn = wrEn;
  end

  assign outValid = validReg;

  // cycles since reset, saturating, for the latency check
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (outValid == $past(inValid, 2))); // R2

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !outValid); // R1

endmodule

// File: rtl/pd_datapath.sv
module pd_datapath
  import pattern_lut_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int HALF_WIN = 5,
  parameter int SAMPLE_W = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  pdStrobe_t                     strobe,
  input  logic [LANES-1:0]              dataIn,
  input  logic [2*HALF_WIN+1:0]         wrAddr,
  input  logic [SAMPLE_W-1:0]           wrData,
  output logic [LANES*2*SAMPLE_W-1:0]   dataOut
);

  localparam int WIN  = 2 * HALF_WIN + 1;
  localparam int SR_W = 2 * HALF_WIN + LANES;

  // bit stream window: index 0 oldest, new word enters at the top
  logic [SR_W-1:0] winReg;

  always_ff @(posedge clk) begin
    if (rst) winReg <= '0;
    else if (strobe.shiftEn) winReg <= {dataIn, winReg[SR_W-1:LANES]};
  end

  logic [WIN-1:0] wrPat;
  logic           wrPh;
  assign wrPat = wrAddr[WIN:1];
  assign wrPh  = wrAddr[0];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [WIN-1:0]           lanePat;
    logic [1:0][SAMPLE_W-1:0] lanePair;

    // lane j is centred on window index j+HALF_WIN
    assign lanePat = winReg[j +: WIN];

    pd_lane_table #(
      .PAT_W   (WIN),
      .SAMPLE_W(SAMPLE_W)
    ) u_table (
      .clk    (clk),
      .rst    (rst),
      .readEn (strobe.readEn),
      .rdPat  (lanePat),
      .writeEn(strobe.writeEn),
      .wrPat  (wrPat),
      .wrPh   (wrPh),
      .wrData (wrData),
      .rdPair (lanePair)
    );

    assign dataOut[j*2*SAMPLE_W +: 2*SAMPLE_W] = lanePair;
  end

  AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.shiftEn |=> $stable(winReg)); // R4

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.readEn |=> $stable(dataOut)); // R8

endmodule

// File: rtl/pattern_lut_predist.sv
module pattern_lut_predist
  import pattern_lut_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int HALF_WIN = 5,
  parameter int SAMPLE_W = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  input  logic [LANES-1:0]            dataIn,
  input  logic                        wrEn,
  input  logic [2*HALF_WIN+1:0]       wrAddr,
  input  logic [SAMPLE_W-1:0]         wrData,
  output logic                        outValid,
  output logic [LANES*2*SAMPLE_W-1:0] dataOut
);

  pdStrobe_t strobe;

  pd_control u_control (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .wrEn    (wrEn),
    .strobe  (strobe),
    .outValid(outValid)
  );

  pd_datapath #(
    .LANES   (LANES),
    .HALF_WIN(HALF_WIN),
    .SAMPLE_W(SAMPLE_W)
  ) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .dataIn (dataIn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .dataOut(dataOut)
  );

endmodule

// File: tb/pattern_lut_predist_bench.sv
module pattern_lut_predist_bench;

  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 2;
  localparam int HALF       = 5;
  localparam int WIN        = 2 * HALF + 1;
  localparam int SW         = 6;
  localparam int OUT_W      = LANES * 2 * SW;
  localparam int ENTRIES    = 1 << (WIN + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [LANES-1:0] dataIn = '0;
  logic wrEn = 1'b0;
  logic [WIN:0] wrAddr = '0;
  logic [SW-1:0] wrData = '0;
  logic outValid;
  logic [OUT_W-1:0] dataOut;

  pattern_lut_predist #(.LANES(LANES), .HALF_WIN(HALF), .SAMPLE_W(SW)) u_pattern_lut_predist (
    .clk(clk), .rst(rst), .inValid(inValid), .dataIn(dataIn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outValid(outValid), .dataOut(dataOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // bench model state
  logic [SW-1:0] tbl [ENTRIES];
  bit streamQ[$];
  int wordCnt = 0;
  string curTag = "R3";

  logic [OUT_W-1:0] expQ[$];
  int cycQ[$];
  string tagQ[$];
  logic [OUT_W-1:0] lastOut = '0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [SW-1:0] fillVal(input int i);
    return SW'((i * 29) ^ (i >> 3) ^ 5);
  endfunction

  task automatic step(input logic v, input logic [LANES-1:0] w, input logic we,
                      input logic [WIN:0] wa, input logic [SW-1:0] wd);
    logic [OUT_W-1:0] e;
    @(negedge clk);
    inValid = v; dataIn = w; wrEn = we; wrAddr = wa; wrData = wd;
    if (we) tbl[wa] = wd;
    if (v) begin
      for (int j = 0; j < LANES; j++) streamQ.push_back(w[j]);
      e = '0;
      for (int j = 0; j < LANES; j++) begin
        int n;
        logic [WIN-1:0] pat;
        n = wordCnt * LANES + j - HALF;
        pat = '0;
        for (int m = 0; m < WIN; m++) pat[m] = streamQ[n - HALF + m + 2 * HALF];
        for (int p = 0; p < 2; p++) e[(2*j+p)*SW +: SW] = tbl[{pat, p[0]}];
      end
      expQ.push_back(e);
      cycQ.push_back(cyc);
      tagQ.push_back(curTag);
      wordCnt++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, '0);
  endtask

  // monitor: compare results against the scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected outValid", 64'(outValid), 64'd0);
        end else begin
          logic [OUT_W-1:0] e;
          int c;
          string t;
          e = expQ.pop_front();
          c = cycQ.pop_front();
          t = tagQ.pop_front();
          check(cyc == c + 2, "R2 latency", 64'(cyc - c), 64'd2);
          check(dataOut === e, t, 64'(dataOut), 64'(e));
        end
        lastOut = dataOut;
      end else begin
        if (cycQ.size() > 0 && cycQ[0] + 2 <= cyc) begin
          check(1'b0, "R2 missing outValid", 64'd0, 64'd1);
          void'(expQ.pop_front());
          void'(cycQ.pop_front());
          void'(tagQ.pop_front());
        end
        check(dataOut === lastOut, "R8 hold", 64'(dataOut), 64'(lastOut));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 2 * HALF; i++) streamQ.push_back(1'b0);
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R1 outValid in reset", 64'(outValid), 64'd0);
    check(dataOut === '0, "R1 dataOut in reset", 64'(dataOut), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid === 1'b0, "R1 outValid after reset", 64'(outValid), 64'd0);
    check(dataOut === '0, "R1 dataOut after reset", 64'(dataOut), 64'd0);
    running = 1'b1;

    // fill every entry of every lane copy through the shared port (R6)
    for (int i = 0; i < ENTRIES; i++) step(1'b0, '0, 1'b1, (WIN+1)'(i), fillVal(i));
    idle(3);

    curTag = "R3 zeros";
    for (int i = 0; i < 8; i++) step(1'b1, '0, 1'b0, '0, '0);
    curTag = "R6 ones";
    for (int i = 0; i < 8; i++) step(1'b1, '1, 1'b0, '0, '0);
    curTag = "R5 alternating";
    for (int i = 0; i < 8; i++) step(1'b1, LANES'(2'b01), 1'b0, '0, '0);
    curTag = "R3 impulse";
    for (int i = 0; i < 8; i++) step(1'b1, '0, 1'b0, '0, '0);
    step(1'b1, LANES'(1), 1'b0, '0, '0);
    for (int i = 0; i < 8; i++) step(1'b1, '0, 1'b0, '0, '0);
    idle(2);

    curTag = "R4 random";
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(1'b1, lfsr[LANES-1:0], 1'b0, '0, '0);
    end
    curTag = "R4 gaps";
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[7] | lfsr[3], lfsr[LANES-1:0], 1'b0, '0, '0);
    end
    idle(3);

    // live update on the all-ones pattern: same cycle sees new, next cycle old
    curTag = "R7 live write";
    for (int i = 0; i < 6; i++) step(1'b1, '1, 1'b0, '0, '0);
    step(1'b1, '1, 1'b1, {{WIN{1'b1}}, 1'b0}, 6'h2A);
    step(1'b1, '1, 1'b1, {{WIN{1'b1}}, 1'b1}, 6'h15);
    step(1'b1, '1, 1'b1, {{WIN{1'b1}}, 1'b0}, 6'h07);
    step(1'b1, '1, 1'b0, '0, '0);
    step(1'b0, '0, 1'b1, {{WIN{1'b1}}, 1'b1}, 6'h3C);
    step(1'b1, '1, 1'b0, '0, '0);
    idle(6);

    check(expQ.size() == 0, "R2 drained", 64'(expQ.size()), 64'd0);
    running = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule